// File: doc/BRIEF.md
# Reference Clock Divider with Selectable Frequency Output

This block turns a fast reference into a one-second heartbeat for a calendar counter. It runs on a clock at twice the reference rate. A binary ripple-free counter then produces the reference square wave at its lowest stage, and each higher stage runs at half the rate of the one below it. The top stage is a 1 Hz square wave with a 50 % duty cycle. A single-cycle seconds pulse marks each rising edge of that top stage. The calendar uses this pulse to advance.

A frequency output is built from the same counter. A select input picks either the reference stage or the 1 Hz stage. An enable input gates the output. The output is modelled as a value plus an enable, and a disabled output drives value 0 with enable low. A serial write controller can pulse a clear input. The clear zeroes the slow stages, from the 128 Hz stage up to the 1 Hz stage. The fast stages keep counting, so a newly written time starts on a full second.

With the default 16-bit counter, bit 0 is the reference and bit 15 is 1 Hz. The clear covers bits 15 down to 8. Both widths are parameters.

Top module: `refdiv_top`

## Requirements
- R1: While the active-low reset is held, the counter is zero. With select high and enable high, `fout_val_o` is 0 and `sec_tick_o` is 0.
- R2: With enable high and select low, `fout_val_o` equals counter bit 0. It inverts on every clock edge, which gives the reference square wave at half the clock rate.
- R3: With enable high and select high, `fout_val_o` equals counter bit DIV_W-1. Without a clear, this bit stays high for exactly 2^(DIV_W-1) cycles and then low for the same number of cycles (50 % duty).
- R4: With enable low, `fout_en_o` is 0 and `fout_val_o` is 0 in the same cycle. With enable high, `fout_en_o` is 1. The enable has no other effect on the counter.
- R5: `sec_tick_o` is high for exactly one cycle. It is high in the same cycle in which counter bit DIV_W-1 changes from 0 to 1, and in no other cycle.
- R6: When `div_clr_i` is high at a clock edge, counter bits DIV_W-1..CLR_LSB become 0. Bits CLR_LSB-1..0 advance by one, modulo 2^CLR_LSB. The next seconds pulse therefore comes exactly 2^(DIV_W-1) minus (those low bits) cycles later.
- R7: No seconds pulse is produced at a clock edge where `div_clr_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the reference frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_clr_i | input | 1 | Strobe that clears the slow divider stages |
| sel_sec_i | input | 1 | 1: output the 1 Hz stage; 0: output the reference stage |
| out_oe_i | input | 1 | Output enable |
| fout_val_o | output | 1 | Frequency output value (0 when disabled) |
| fout_en_o | output | 1 | Frequency output drive enable |
| sec_tick_o | output | 1 | One-cycle pulse on each 1 Hz rising edge |

## Verification
A corrupted counter bit does not always show at the ports at once. A wrong bit 0 shows on the next cycle with select low. A wrong slow-stage bit stays hidden until it changes the moment the top bit toggles. That can take up to 2^(DIV_W-1) cycles, when the seconds pulse comes early or late and the high or low phase has the wrong length. A small configuration keeps that delay to a few dozen cycles. The bench also applies a clear at every counter offset, so a bad carry or a bad clear mask moves the next pulse within one period.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_SEC = 1'b1
    } fout_src_e;

endpackage

// File: rtl/refdiv_chain.sv
module refdiv_chain #(
    parameter int DIV_W   = 16,
    parameter int CLR_LSB = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic             tick_o
);
    localparam int HI_W = DIV_W - CLR_LSB;
    localparam logic [DIV_W-1:0] LOW_MASK = {{HI_W{1'b0}}, {CLR_LSB{1'b1}}};

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } chain_st_t;

    chain_st_t st_d, st_q;
    logic [DIV_W-1:0] cnt_inc;
    logic             msb_about_to_rise;

    always_comb begin
        st_d              = st_q;
        cnt_inc           = st_q.cnt + 1'b1;
        msb_about_to_rise = (st_q.cnt[DIV_W-2:0] == '1) && !st_q.cnt[DIV_W-1];
        if (clr_i) begin
            st_d.cnt  = cnt_inc & LOW_MASK;
            st_d.tick = 1'b0;
        end else begin
            st_d.cnt  = cnt_inc;
            st_d.tick = msb_about_to_rise;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel
    import refdiv_pkg::*;
(
    input  logic sel_i,
    input  logic oe_i,
    input  logic ref_i,
    input  logic sec_i,
    output logic val_o,
    output logic en_o
);
    fout_src_e src;

    always_comb begin
        src   = fout_src_e'(sel_i);
        val_o = 1'b0;
        en_o  = oe_i;
        if (oe_i) begin
            val_o = (src == SRC_SEC) ? sec_i : ref_i;
        end
    end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int DIV_W   = 16,
    parameter int CLR_LSB = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic div_clr_i,
    input  logic sel_sec_i,
    input  logic out_oe_i,
    output logic fout_val_o,
    output logic fout_en_o,
    output logic sec_tick_o
);
    logic [DIV_W-1:0] cnt_w;

    refdiv_chain #(
        .DIV_W  (DIV_W),
        .CLR_LSB(CLR_LSB)
    ) chain_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (div_clr_i),
        .cnt_o (cnt_w),
        .tick_o(sec_tick_o)
    );

    refdiv_outsel outsel_i (
        .sel_i(sel_sec_i),
        .oe_i (out_oe_i),
        .ref_i(cnt_w[0]),
        .sec_i(cnt_w[DIV_W-1]),
        .val_o(fout_val_o),
        .en_o (fout_en_o)
    );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
    parameter int W = 16,
    parameter int L = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         div_clr_i,
    input logic         sel_sec_i,
    input logic         out_oe_i,
    input logic         fout_val_o,
    input logic         fout_en_o,
    input logic         sec_tick_o,
    input logic [W-1:0] cnt
);
    logic armed_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    AST_SEL_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_oe_i && !sel_sec_i) |-> (fout_val_o == cnt[0])); // R2
    AST_REF_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (cnt[0] != $past(cnt[0]))); // R2
    AST_SEL_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_oe_i && sel_sec_i) |-> (fout_val_o == cnt[W-1])); // R3
    AST_OE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !out_oe_i |-> (!fout_en_o && !fout_val_o)); // R4
    AST_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_oe_i |-> fout_en_o); // R4
    AST_TICK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && sec_tick_o) |-> (cnt[W-1] && !$past(cnt[W-1]))); // R5
    AST_RISE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && cnt[W-1] && !$past(cnt[W-1])) |-> sec_tick_o); // R5
    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_tick_o |=> !sec_tick_o); // R5
    AST_CLR_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_clr_i |=> (cnt[W-1:L] == '0)); // R6
    AST_CLR_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_clr_i |=> (cnt[L-1:0] == L'($past(cnt[L-1:0]) + 1'b1))); // R6
    AST_CLR_NOTICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_clr_i |=> !sec_tick_o); // R7
endmodule

bind refdiv_top refdiv_chk #(
    .W(DIV_W),
    .L(CLR_LSB)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_clr_i (div_clr_i),
    .sel_sec_i (sel_sec_i),
    .out_oe_i  (out_oe_i),
    .fout_val_o(fout_val_o),
    .fout_en_o (fout_en_o),
    .sec_tick_o(sec_tick_o),
    .cnt       (cnt_w)
);

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
    localparam int W    = 6;
    localparam int L    = 3;
    localparam int FULL = 1 << W;
    localparam int HALF = 1 << (W - 1);
    localparam int LOWN = 1 << L;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic sel = 1'b1;
    logic oe = 1'b1;
    logic fval, fen, tick;

    int tests = 0;
    int fails = 0;
    int m = 0;
    logic exp_tick = 1'b0;
    logic last_clr = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refdiv_top #(.DIV_W(W), .CLR_LSB(L)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_clr_i(clr), .sel_sec_i(sel),
        .out_oe_i(oe), .fout_val_o(fval), .fout_en_o(fen), .sec_tick_o(tick)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        logic ev;
        string rq;
        ev = oe ? (sel ? logic'((m >> (W - 1)) & 1) : logic'(m & 1)) : 1'b0;
        rq = !oe ? "R4" : (sel ? "R3" : "R2");
        chk(rq, {ctx, " value"}, fval, ev);
        chk("R4", {ctx, " enable"}, fen, oe);
        chk(last_clr ? "R7" : "R5", {ctx, " tick"}, tick, exp_tick);
    endtask

    // one clock: inputs already driven; update model, check at negedge
    task automatic cyc(input logic c, input string ctx);
        clr = c;
        @(posedge clk);
        exp_tick = !c && (m == HALF - 1);
        m = c ? (m + 1) % LOWN : (m + 1) % FULL;
        last_clr = c;
        @(negedge clk);
        clr = 1'b0;
        check_all(ctx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sel = 1'b1;
        oe = 1'b1;
        clr = 1'b0;
        m = 0;
        exp_tick = 1'b0;
        last_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "reset value", fval, 1'b0);
        chk("R1", "reset tick", tick, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        int run;
        logic prev;
        do_reset();
        // R3 duty: high and low phases each HALF cycles
        run = 0;
        prev = 1'b0;
        for (int i = 0; i < 4 * FULL; i++) begin
            cyc(1'b0, "R3 sweep");
            if (fval == prev) run++;
            else begin
                if (i > HALF) chk("R3", "phase length", logic'(run == HALF), 1'b1);
                run = 1;
                prev = fval;
            end
        end
        // R2 reference stage
        sel = 1'b0;
        for (int i = 0; i < FULL + 5; i++) cyc(1'b0, "R2 sweep");
        // R4 all select/enable combinations
        for (int k = 0; k < 4; k++) begin
            sel = k[0];
            oe = k[1];
            for (int i = 0; i < FULL + 3; i++) cyc(1'b0, "R4 combo");
        end
        // R6 clear applied at every counter offset
        for (int off = 0; off < FULL; off++) begin
            do_reset();
            for (int i = 0; i < off; i++) cyc(1'b0, "R6 pre");
            cyc(1'b1, "R6 clear");
            for (int i = 0; i < FULL + 4; i++) cyc(1'b0, "R6 post");
        end
        // back-to-back clears across a seconds boundary
        do_reset();
        for (int i = 0; i < HALF - 2; i++) cyc(1'b0, "R7 pre");
        for (int i = 0; i < 3 * LOWN; i++) cyc(1'b1, "R7 held clear");
        for (int i = 0; i < FULL; i++) cyc(1'b0, "R6 after held");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule